// File: doc/BRIEF.md
# Ring-Checked Translation Buffer with Single-Read Refill

This block translates 32-bit virtual addresses to physical addresses for either instruction fetches or data loads and stores. Each side has its own set-associative entry store. On a request, every way of the selected side is compared against the virtual page number. An entry counts as a hit only if its address-space identifier (ASID) is nonzero and equals one of the four bytes of a ring-map register; the byte position becomes the entry's privilege ring. The hit is then checked for privilege and access rights, and the block returns either a physical address with decoded rights and a cache mode, or a cause code.

When the lookup misses and the requester allows a refill, the block sends one page-table-entry read to an external memory port. The entry address is formed from a page-table base register and the virtual address; it is used as a physical address with no further walk. The returned word is written into one way picked by a rotating counter, and the access is answered from that new entry. A simple write port loads entries and the two configuration registers.

The controller has three states. ST_IDLE answers lookups. ST_WALK holds the read request until it is acknowledged. ST_FILL writes the refilled entry and answers. Its transitions are: IDLE→IDLE when a lookup is answered or no request is present; IDLE→WALK on a miss with refill allowed; WALK→WALK while there is no acknowledge; WALK→FILL on acknowledge; FILL→IDLE always.

Top module: `tlb_asid_mmu`

## Requirements
- R1: A request accepted in ST_IDLE is answered on `rsp_valid` one cycle later. On a single hit with no fault, `rsp_cause`=0 and `rsp_paddr` = {entry frame, vaddr[11:0]}. Any nonzero cause returns `rsp_paddr`=0. The entry set is vaddr[13:12] and the page number is vaddr[31:12].
- R2: An entry with ASID 0, or with an ASID found in no byte of the ring map, never hits. A lookup with no hit returns cause 1 for a fetch or 2 for a load or store.
- R3: Two or more hitting ways return cause 3 for a fetch or 4 for data.
- R4: After reset, the ring map is 0x04030201 (byte k, at bits [8k+7:8k], holds the ASID of ring k), the refill counter is 0, every entry has ASID 0, `excvaddr` is 0, and `rsp_valid` and `pte_req` are low.
- R5: If the hit ring is lower than `req_level`, the cause is 5 for a fetch or 6 for data.
- R6: On a miss with `req_fill`=1, `pte_req` rises one cycle after acceptance. It stays high with `pte_addr` = (page-table base | vaddr>>10) & ~3 until `pte_ack`.
- R7: On refill, the counter is incremented and its new value selects the way that is written. The written entry has frame = pte[31:12], attr = pte[3:0], and ASID = ring-map byte pte[5:4]. The answer, one cycle after the acknowledge, uses ring pte[5:4] and that attribute. `excvaddr` takes the request address.
- R8: Attribute decoding works as follows. Values below 12 give read, bit 0 gives execute, bit 1 gives write, and bits [3:2] give the cache mode (0 bypass, 1 write-back, 2 write-through). Value 13 gives read, write and cache mode 3 (isolate). Any other value gives no rights. Rights are reported whenever an entry was found, and are all zero on a miss or multi-hit.
- R9: `req_kind` is 0 for a load, 1 for a store and 2 for a fetch. Fetch responses never carry read or write rights, and data responses never carry execute. A missing right gives cause 7 (fetch), 8 (load) or 9 (store).
- R10: `te_we` writes one entry of the side chosen by `te_fetch_side`. `cfg_we` writes the ring map when `cfg_sel`=0 and the page-table base when `cfg_sel`=1.
- R11: While `busy` is high, requests are ignored: no response is produced for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_level | input | 2 | Requested privilege level |
| req_fill | input | 1 | Allow refill on miss |
| busy | output | 1 | Refill in progress |
| rsp_valid | output | 1 | Response strobe |
| rsp_cause | output | 4 | 0 OK, else cause code |
| rsp_paddr | output | 32 | Physical address |
| rsp_read | output | 1 | Read right |
| rsp_write | output | 1 | Write right |
| rsp_exec | output | 1 | Execute right |
| rsp_cache | output | 2 | Cache mode |
| excvaddr | output | 32 | Last refilled virtual address |
| pte_req | output | 1 | Page-table read request |
| pte_addr | output | 32 | Page-table entry address |
| pte_ack | input | 1 | Read data valid |
| pte_data | input | 32 | Page-table entry |
| te_we | input | 1 | Entry write enable |
| te_fetch_side | input | 1 | 1 instruction side, 0 data side |
| te_way | input | 2 | Way to write |
| te_set | input | 2 | Set to write |
| te_vpn | input | 20 | Page number |
| te_ppn | input | 20 | Physical frame |
| te_asid | input | 8 | ASID |
| te_attr | input | 4 | Attribute |
| cfg_we | input | 1 | Config write enable |
| cfg_sel | input | 1 | 0 ring map, 1 page-table base |
| cfg_wdata | input | 32 | Config write data |

## Verification
The assertions assume that `pte_ack` is raised only while `pte_req` is high, that `req_kind` never takes the value 3, and that no entry write targets the side being refilled during ST_FILL. The bench meets these assumptions by construction. It acknowledges only after seeing `pte_req` high, uses only the three defined kinds, and performs every entry and config write while `busy` is low. The checker keeps its own copy of the last accepted request's kind and address offset, so it can relate each response to the request that caused it.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;
    localparam int unsigned VA_W       = 32;
    localparam int unsigned PAGE_BITS  = 12;
    localparam int unsigned VPN_W      = VA_W - PAGE_BITS;
    localparam int unsigned ASID_W     = 8;
    localparam int unsigned RINGS      = 4;
    localparam int unsigned RING_W     = $clog2(RINGS);
    localparam int unsigned RMAP_W     = ASID_W * RINGS;
    localparam int unsigned ATTR_W     = 4;
    localparam int unsigned PTE_SHIFT  = PAGE_BITS - 2;
    localparam int unsigned PTE_RING_LSB = 4;
    localparam logic [RMAP_W-1:0] RMAP_RESET = 32'h0403_0201;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [3:0] {
        CZ_OK         = 4'd0,
        CZ_IMISS      = 4'd1,
        CZ_DMISS      = 4'd2,
        CZ_IMULTI     = 4'd3,
        CZ_DMULTI     = 4'd4,
        CZ_IPRIV      = 4'd5,
        CZ_DPRIV      = 4'd6,
        CZ_FETCH_DENY = 4'd7,
        CZ_LOAD_DENY  = 4'd8,
        CZ_STORE_DENY = 4'd9
    } cause_e;

    typedef enum logic [1:0] {
        CM_BYPASS  = 2'd0,
        CM_WBACK   = 2'd1,
        CM_WTHRU   = 2'd2,
        CM_ISOLATE = 2'd3
    } cache_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic [ATTR_W-1:0] attr;
    } tlb_ent_t;
endpackage

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode
    import tlb_asid_pkg::*;
(
    input  logic [ATTR_W-1:0] attr,
    input  logic              fetch_side,
    output logic              rd,
    output logic              wr,
    output logic              ex,
    output cache_e            cache
);
    logic r_raw, w_raw, x_raw;

    always_comb begin
        r_raw = 1'b0;
        w_raw = 1'b0;
        x_raw = 1'b0;
        cache = CM_BYPASS;
        if (attr < 4'd12) begin
            r_raw = 1'b1;
            x_raw = attr[0];
            w_raw = attr[1];
            cache = cache_e'(attr[3:2]);
        end else if (attr == 4'd13) begin
            r_raw = 1'b1;
            w_raw = 1'b1;
            cache = CM_ISOLATE;
        end
        // each side keeps only the rights it can use
        rd = r_raw & ~fetch_side;
        wr = w_raw & ~fetch_side;
        ex = x_raw &  fetch_side;
    end
endmodule

// File: rtl/tlb_way_array.sv
module tlb_way_array
    import tlb_asid_pkg::*;
#(
    parameter  int unsigned NWAYS = 4,
    parameter  int unsigned NSETS = 4,
    localparam int unsigned WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int unsigned SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [WAY_W-1:0]           wr_way,
    input  logic [SET_W-1:0]           wr_set,
    input  tlb_ent_t                   wr_ent,
    input  logic [SET_W-1:0]           rd_set,
    output tlb_ent_t [NWAYS-1:0]       rd_ent
);
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        tlb_ent_t mem [NSETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < NSETS; i++) mem[i] <= '0;
            end else if (wr_en && wr_way == WAY_W'(w)) begin
                mem[wr_set] <= wr_ent;
            end
        end

        assign rd_ent[w] = mem[rd_set];
    end
endmodule

// File: rtl/tlb_hit_resolve.sv
module tlb_hit_resolve
    import tlb_asid_pkg::*;
#(
    parameter  int unsigned NWAYS = 4,
    localparam int unsigned CNT_W = $clog2(NWAYS + 1)
) (
    input  tlb_ent_t [NWAYS-1:0] ents,
    input  logic [VPN_W-1:0]     vpn,
    input  logic [RMAP_W-1:0]    rmap,
    output logic                 hit,
    output logic                 multi,
    output logic [RING_W-1:0]    ring,
    output tlb_ent_t             ent
);
    // returns {found, ring index}; lowest matching byte wins
    function automatic logic [RING_W:0] ring_of(input logic [ASID_W-1:0] asid,
                                                input logic [RMAP_W-1:0] map);
        logic [RING_W:0] res;
        res = '0;
        for (int r = RINGS - 1; r >= 0; r--) begin
            if (map[r*ASID_W +: ASID_W] == asid) res = {1'b1, RING_W'(r)};
        end
        return res;
    endfunction

    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt  = '0;
        ring = '0;
        ent  = '0;
        for (int w = 0; w < NWAYS; w++) begin
            logic [RING_W:0] lk;
            lk = ring_of(ents[w].asid, rmap);
            if (ents[w].asid != '0 && ents[w].vpn == vpn && lk[RING_W]) begin
                cnt  = cnt + 1'b1;
                ring = lk[RING_W-1:0];
                ent  = ents[w];
            end
        end
        hit   = (cnt != '0);
        multi = (cnt > CNT_W'(1));
    end
endmodule

// File: rtl/tlb_asid_mmu.sv
module tlb_asid_mmu
    import tlb_asid_pkg::*;
#(
    parameter  int unsigned NWAYS = 4,
    parameter  int unsigned NSETS = 4,
    localparam int unsigned WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int unsigned SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [RING_W-1:0] req_level,
    input  logic              req_fill,
    output logic              busy,
    output logic              rsp_valid,
    output logic [3:0]        rsp_cause,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic              rsp_read,
    output logic              rsp_write,
    output logic              rsp_exec,
    output logic [1:0]        rsp_cache,
    output logic [VA_W-1:0]   excvaddr,
    output logic              pte_req,
    output logic [VA_W-1:0]   pte_addr,
    input  logic              pte_ack,
    input  logic [VA_W-1:0]   pte_data,
    input  logic              te_we,
    input  logic              te_fetch_side,
    input  logic [WAY_W-1:0]  te_way,
    input  logic [SET_W-1:0]  te_set,
    input  logic [VPN_W-1:0]  te_vpn,
    input  logic [VPN_W-1:0]  te_ppn,
    input  logic [ASID_W-1:0] te_asid,
    input  logic [ATTR_W-1:0] te_attr,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [VA_W-1:0]   cfg_wdata
);
    typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_FILL} st_e;

    st_e st_q, st_d;

    logic [VA_W-1:0]   lat_vaddr;
    acc_kind_e         lat_kind;
    logic [RING_W-1:0] lat_level;
    logic [VA_W-1:0]   lat_pte;
    logic [WAY_W-1:0]  fill_ctr;
    logic [RMAP_W-1:0] rmap_q;
    logic [VA_W-1:0]   ptbase_q;
    logic [VA_W-1:0]   excv_q;
    logic              unused_pte_bits;

    // current operand: the live request in ST_IDLE, the latched one in ST_FILL
    logic              in_fill;
    logic [VA_W-1:0]   cur_vaddr;
    acc_kind_e         cur_kind;
    logic [RING_W-1:0] cur_level;
    logic              cur_fetch;
    logic [VPN_W-1:0]  cur_vpn;
    logic [SET_W-1:0]  cur_set;

    assign in_fill   = (st_q == ST_FILL);
    assign cur_vaddr = in_fill ? lat_vaddr : req_vaddr;
    assign cur_kind  = in_fill ? lat_kind  : acc_kind_e'(req_kind);
    assign cur_level = in_fill ? lat_level : req_level;
    assign cur_fetch = (cur_kind == ACC_FETCH);
    assign cur_vpn   = cur_vaddr[VA_W-1:PAGE_BITS];
    assign cur_set   = cur_vaddr[PAGE_BITS +: SET_W];

    assign unused_pte_bits = ^lat_pte[PAGE_BITS-1:PTE_RING_LSB+RING_W];

    // refill entry built from the returned page-table word
    logic [RING_W-1:0] pte_ring;
    logic [WAY_W-1:0]  fill_way;
    tlb_ent_t          fill_ent;

    assign pte_ring      = lat_pte[PTE_RING_LSB +: RING_W];
    assign fill_way      = WAY_W'(fill_ctr + 1'b1);
    assign fill_ent.vpn  = lat_vaddr[VA_W-1:PAGE_BITS];
    assign fill_ent.ppn  = lat_pte[VA_W-1:PAGE_BITS];
    assign fill_ent.asid = rmap_q[pte_ring*ASID_W +: ASID_W];
    assign fill_ent.attr = lat_pte[ATTR_W-1:0];

    // one entry store per side: index 0 data, index 1 instruction
    tlb_ent_t [1:0][NWAYS-1:0] side_ents;

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam bit IS_FETCH = (s == 1);
        logic             s_we;
        logic [WAY_W-1:0] s_way;
        logic [SET_W-1:0] s_set;
        tlb_ent_t         s_wd;

        always_comb begin
            s_we  = 1'b0;
            s_way = te_way;
            s_set = te_set;
            s_wd  = '{vpn: te_vpn, ppn: te_ppn, asid: te_asid, attr: te_attr};
            if (in_fill && ((lat_kind == ACC_FETCH) == IS_FETCH)) begin
                s_we  = 1'b1;
                s_way = fill_way;
                s_set = lat_vaddr[PAGE_BITS +: SET_W];
                s_wd  = fill_ent;
            end else if (te_we && (te_fetch_side == IS_FETCH)) begin
                s_we  = 1'b1;
            end
        end

        tlb_way_array #(.NWAYS(NWAYS), .NSETS(NSETS)) u_arr (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (s_we),
            .wr_way (s_way),
            .wr_set (s_set),
            .wr_ent (s_wd),
            .rd_set (cur_set),
            .rd_ent (side_ents[s])
        );
    end

    logic              hit, multi;
    logic [RING_W-1:0] hit_ring;
    tlb_ent_t          hit_ent;

    tlb_hit_resolve #(.NWAYS(NWAYS)) u_hit (
        .ents  (side_ents[cur_fetch]),
        .vpn   (cur_vpn),
        .rmap  (rmap_q),
        .hit   (hit),
        .multi (multi),
        .ring  (hit_ring),
        .ent   (hit_ent)
    );

    logic [ATTR_W-1:0] src_attr;
    logic [RING_W-1:0] src_ring;
    logic [VPN_W-1:0]  src_ppn;
    logic              dec_rd, dec_wr, dec_ex;
    cache_e            dec_cache;

    assign src_attr = in_fill ? fill_ent.attr : hit_ent.attr;
    assign src_ring = in_fill ? pte_ring      : hit_ring;
    assign src_ppn  = in_fill ? fill_ent.ppn  : hit_ent.ppn;

    tlb_attr_decode u_dec (
        .attr       (src_attr),
        .fetch_side (cur_fetch),
        .rd         (dec_rd),
        .wr         (dec_wr),
        .ex         (dec_ex),
        .cache      (dec_cache)
    );

    logic   granted, have_ent;
    cause_e cause;

    always_comb begin
        unique case (cur_kind)
            ACC_LOAD:  granted = dec_rd;
            ACC_STORE: granted = dec_wr;
            ACC_FETCH: granted = dec_ex;
            default:   granted = 1'b0;
        endcase
        have_ent = in_fill || (hit && !multi);
        if (!in_fill && multi)
            cause = cur_fetch ? CZ_IMULTI : CZ_DMULTI;
        else if (!in_fill && !hit)
            cause = cur_fetch ? CZ_IMISS : CZ_DMISS;
        else if (src_ring < cur_level)
            cause = cur_fetch ? CZ_IPRIV : CZ_DPRIV;
        else if (!granted)
            cause = cur_fetch ? CZ_FETCH_DENY :
                    (cur_kind == ACC_STORE) ? CZ_STORE_DENY : CZ_LOAD_DENY;
        else
            cause = CZ_OK;
    end

    logic accept, go_walk, rsp_load;
    assign accept   = (st_q == ST_IDLE) && req_valid;
    assign go_walk  = accept && req_fill && (cause == CZ_IMISS || cause == CZ_DMISS);
    assign rsp_load = (accept && !go_walk) || in_fill;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (go_walk) st_d = ST_WALK;
            ST_WALK: if (pte_ack) st_d = ST_FILL;
            ST_FILL: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // latched request, page-table word, refill counter and config
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_vaddr <= '0;
            lat_kind  <= ACC_LOAD;
            lat_level <= '0;
            lat_pte   <= '0;
            fill_ctr  <= '0;
            excv_q    <= '0;
            rmap_q    <= RMAP_RESET;
            ptbase_q  <= '0;
        end else begin
            if (go_walk) begin
                lat_vaddr <= req_vaddr;
                lat_kind  <= acc_kind_e'(req_kind);
                lat_level <= req_level;
            end
            if (st_q == ST_WALK && pte_ack) lat_pte <= pte_data;
            if (in_fill) begin
                fill_ctr <= fill_way;
                excv_q   <= lat_vaddr;
            end
            if (cfg_we) begin
                if (cfg_sel) ptbase_q <= cfg_wdata;
                else         rmap_q   <= cfg_wdata;
            end
        end
    end

    // registered response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
            rsp_read  <= 1'b0;
            rsp_write <= 1'b0;
            rsp_exec  <= 1'b0;
            rsp_cache <= '0;
        end else begin
            rsp_valid <= rsp_load;
            if (rsp_load) begin
                rsp_cause <= cause;
                rsp_paddr <= (cause == CZ_OK) ? {src_ppn, cur_vaddr[PAGE_BITS-1:0]} : '0;
                rsp_read  <= have_ent & dec_rd;
                rsp_write <= have_ent & dec_wr;
                rsp_exec  <= have_ent & dec_ex;
                rsp_cache <= have_ent ? dec_cache : CM_BYPASS;
            end
        end
    end

    assign busy     = (st_q != ST_IDLE);
    assign excvaddr = excv_q;
    assign pte_req  = (st_q == ST_WALK);
    assign pte_addr = (ptbase_q | (lat_vaddr >> PTE_SHIFT)) & ~VA_W'(3);
endmodule

// File: rtl/tlb_asid_mmu_chk.sv
module tlb_asid_mmu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic [1:0]  req_kind,
    input logic        busy,
    input logic        rsp_valid,
    input logic [3:0]  rsp_cause,
    input logic [31:0] rsp_paddr,
    input logic        rsp_read,
    input logic        rsp_write,
    input logic        rsp_exec,
    input logic        pte_req,
    input logic [31:0] pte_addr,
    input logic        pte_ack
);
    logic [1:0]  chk_kind;
    logic [11:0] chk_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_kind <= 2'd0;
            chk_off  <= '0;
        end else if (req_valid && !busy) begin
            chk_kind <= req_kind;
            chk_off  <= req_vaddr[11:0];
        end
    end

    assert_pte_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pte_req && !pte_ack |=> pte_req && $stable(pte_addr));

    assert_pte_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pte_req |-> pte_addr[1:0] == 2'b00);

    assert_walk_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pte_req |-> !rsp_valid);

    assert_fetch_strip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && chk_kind == 2'd2 |-> !rsp_read && !rsp_write);

    assert_data_strip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && chk_kind != 2'd2 |-> !rsp_exec);

    assert_fault_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cause != 4'd0 |-> rsp_paddr == 32'd0);

    assert_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cause == 4'd0 |-> rsp_paddr[11:0] == chk_off);

    assert_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cause == 4'd0 |->
            (chk_kind == 2'd0 ? rsp_read : chk_kind == 2'd1 ? rsp_write : rsp_exec));

    assert_miss_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_cause == 4'd1 |-> chk_kind == 2'd2);
endmodule

bind tlb_asid_mmu tlb_asid_mmu_chk u_chk (.*);

// File: tb/tlb_asid_mmu_tb.sv
module tlb_asid_mmu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_level = '0;
    logic        req_fill = 1'b0;
    logic        busy, rsp_valid, rsp_read, rsp_write, rsp_exec, pte_req;
    logic [3:0]  rsp_cause;
    logic [31:0] rsp_paddr, excvaddr, pte_addr;
    logic [1:0]  rsp_cache;
    logic        pte_ack = 1'b0;
    logic [31:0] pte_data = '0;
    logic        te_we = 1'b0, te_fetch_side = 1'b0;
    logic [1:0]  te_way = '0, te_set = '0;
    logic [19:0] te_vpn = '0, te_ppn = '0;
    logic [7:0]  te_asid = '0;
    logic [3:0]  te_attr = '0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tlb_asid_mmu u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .req_level(req_level), .req_fill(req_fill), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
        .rsp_read(rsp_read), .rsp_write(rsp_write), .rsp_exec(rsp_exec),
        .rsp_cache(rsp_cache), .excvaddr(excvaddr),
        .pte_req(pte_req), .pte_addr(pte_addr), .pte_ack(pte_ack), .pte_data(pte_data),
        .te_we(te_we), .te_fetch_side(te_fetch_side), .te_way(te_way), .te_set(te_set),
        .te_vpn(te_vpn), .te_ppn(te_ppn), .te_asid(te_asid), .te_attr(te_attr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata)
    );

    task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_entry(input bit iside, input int way, input int set,
                             input logic [19:0] vpn, input logic [19:0] ppn,
                             input logic [7:0] asid, input logic [3:0] attr);
        @(negedge clk);
        te_we = 1'b1; te_fetch_side = iside; te_way = 2'(way); te_set = 2'(set);
        te_vpn = vpn; te_ppn = ppn; te_asid = asid; te_attr = attr;
        @(negedge clk);
        te_we = 1'b0;
    endtask

    task automatic put_cfg(input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // rights packed as {read, write, exec, cache[1:0]}
    task automatic look(input logic [31:0] va, input logic [1:0] kind, input logic [1:0] lvl,
                        input logic [3:0] ecause, input logic [31:0] epa,
                        input logic [4:0] erights, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_level = lvl; req_fill = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        expect_eq({tag, " valid"}, 32'(rsp_valid), 32'd1);
        expect_eq({tag, " cause"}, 32'(rsp_cause), 32'(ecause));
        expect_eq({tag, " paddr"}, rsp_paddr, epa);
        expect_eq({tag, " rights"}, 32'({rsp_read, rsp_write, rsp_exec, rsp_cache}), 32'(erights));
        expect_eq({tag, " no walk"}, 32'(pte_req), 32'd0);
    endtask

    task automatic t_reset;
        expect_eq("R4 rsp_valid idle", 32'(rsp_valid), 32'd0);
        expect_eq("R4 pte_req idle", 32'(pte_req), 32'd0);
        expect_eq("R4 excvaddr", excvaddr, 32'd0);
        expect_eq("R4 busy", 32'(busy), 32'd0);
        look(32'h1234_5abc, 2'd0, 2'd0, 4'd2, 32'd0, 5'd0, "R4 empty entries miss");
        look(32'h1234_5abc, 2'd2, 2'd0, 4'd1, 32'd0, 5'd0, "R2 empty fetch miss");
    endtask

    task automatic t_hit;
        put_entry(1'b0, 0, 1, 20'h12345, 20'hABCDE, 8'd4, 4'h6);
        look(32'h1234_5abc, 2'd0, 2'd3, 4'd0, 32'hABCD_Eabc, 5'b11001, "R1 load hit ring3");
        look(32'h1234_5abc, 2'd1, 2'd0, 4'd0, 32'hABCD_Eabc, 5'b11001, "R8 store hit wb");
        look(32'h1234_5abc, 2'd2, 2'd0, 4'd1, 32'd0, 5'd0, "R2 other side miss");
    endtask

    task automatic t_priv;
        put_entry(1'b0, 1, 2, 20'h00002, 20'h55555, 8'd1, 4'h3);
        look(32'h0000_2100, 2'd0, 2'd1, 4'd6, 32'd0, 5'b11000, "R5 data ring0 below level1");
        look(32'h0000_2100, 2'd0, 2'd0, 4'd0, 32'h5555_5100, 5'b11000, "R4 reset ring map ring0");
        put_entry(1'b1, 2, 0, 20'h40000, 20'h00111, 8'd2, 4'h5);
        look(32'h4000_0010, 2'd2, 2'd1, 4'd0, 32'h0011_1010, 5'b00101, "R9 fetch exec only");
        look(32'h4000_0010, 2'd2, 2'd2, 4'd5, 32'd0, 5'b00101, "R5 fetch privilege");
        look(32'h4000_0010, 2'd0, 2'd0, 4'd2, 32'd0, 5'd0, "R2 data side separate");
    endtask

    task automatic t_deny;
        put_entry(1'b0, 3, 3, 20'h0000F, 20'h0ABCD, 8'd3, 4'h4);
        look(32'h0000_F000, 2'd1, 2'd2, 4'd9, 32'd0, 5'b10001, "R9 store prohibited");
        look(32'h0000_F000, 2'd0, 2'd2, 4'd0, 32'h0ABC_D000, 5'b10001, "R8 read only wb");
        put_entry(1'b0, 3, 3, 20'h0000F, 20'h0ABCD, 8'd3, 4'd13);
        look(32'h0000_F000, 2'd1, 2'd2, 4'd0, 32'h0ABC_D000, 5'b11011, "R8 isolate rw");
        put_entry(1'b0, 3, 3, 20'h0000F, 20'h0ABCD, 8'd3, 4'd12);
        look(32'h0000_F000, 2'd0, 2'd2, 4'd8, 32'd0, 5'd0, "R8 attr12 no rights load");
        put_entry(1'b1, 2, 0, 20'h40000, 20'h00111, 8'd2, 4'h2);
        look(32'h4000_0010, 2'd2, 2'd1, 4'd7, 32'd0, 5'd0, "R9 fetch prohibited");
    endtask

    task automatic t_asid;
        put_entry(1'b0, 0, 0, 20'h70000, 20'h01234, 8'd0, 4'h4);
        look(32'h7000_0000, 2'd0, 2'd0, 4'd2, 32'd0, 5'd0, "R2 asid zero never hits");
        put_entry(1'b0, 0, 0, 20'h70000, 20'h01234, 8'd9, 4'h4);
        look(32'h7000_0000, 2'd0, 2'd0, 4'd2, 32'd0, 5'd0, "R2 asid not in ring map");
        put_cfg(1'b0, 32'h0903_0201);
        look(32'h7000_0000, 2'd0, 2'd3, 4'd0, 32'h0123_4000, 5'b10001, "R10 ring map write");
        put_cfg(1'b0, 32'h0403_0201);
    endtask

    task automatic t_multi;
        put_entry(1'b0, 1, 1, 20'h12345, 20'h00077, 8'd3, 4'h6);
        look(32'h1234_5abc, 2'd0, 2'd0, 4'd4, 32'd0, 5'd0, "R3 data multi hit");
        put_entry(1'b1, 1, 0, 20'h40000, 20'h00088, 8'd2, 4'h5);
        look(32'h4000_0010, 2'd2, 2'd0, 4'd3, 32'd0, 5'd0, "R3 fetch multi hit");
        put_entry(1'b0, 1, 1, 20'h12345, 20'h00077, 8'd0, 4'h6);
        look(32'h1234_5abc, 2'd0, 2'd3, 4'd0, 32'hABCD_Eabc, 5'b11001, "R10 entry cleared");
    endtask

    task automatic do_refill(input logic [31:0] va, input logic [1:0] lvl,
                             input logic [31:0] epte_addr, input logic [31:0] pte,
                             input bit poke_busy,
                             input logic [3:0] ecause, input logic [31:0] epa,
                             input logic [4:0] erights, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = 2'd0; req_level = lvl; req_fill = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_fill = 1'b0;
        expect_eq({tag, " R6 pte_req"}, 32'(pte_req), 32'd1);
        expect_eq({tag, " R6 pte_addr"}, pte_addr, epte_addr);
        expect_eq({tag, " R6 no early rsp"}, 32'(rsp_valid), 32'd0);
        if (poke_busy) begin
            req_valid = 1'b1; req_vaddr = 32'h2222_3000; req_kind = 2'd0; req_level = 2'd0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        expect_eq({tag, " R6 pte_req held"}, 32'(pte_req), 32'd1);
        expect_eq({tag, " R6 pte_addr held"}, pte_addr, epte_addr);
        expect_eq({tag, " R11 busy silent"}, 32'(rsp_valid), 32'd0);
        pte_ack = 1'b1; pte_data = pte;
        @(negedge clk);
        pte_ack = 1'b0;
        expect_eq({tag, " R7 fill no rsp yet"}, 32'(rsp_valid), 32'd0);
        @(negedge clk);
        expect_eq({tag, " R7 rsp valid"}, 32'(rsp_valid), 32'd1);
        expect_eq({tag, " R7 cause"}, 32'(rsp_cause), 32'(ecause));
        expect_eq({tag, " R7 paddr"}, rsp_paddr, epa);
        expect_eq({tag, " R7 rights"}, 32'({rsp_read, rsp_write, rsp_exec, rsp_cache}), 32'(erights));
        expect_eq({tag, " R7 excvaddr"}, excvaddr, va);
        @(negedge clk);
        expect_eq({tag, " R11 single rsp"}, 32'(rsp_valid), 32'd0);
        expect_eq({tag, " idle after fill"}, 32'(busy), 32'd0);
    endtask

    task automatic t_refill;
        put_cfg(1'b1, 32'h8000_0000);
        put_entry(1'b0, 1, 3, 20'h11113, 20'h11111, 8'd1, 4'h4);
        put_entry(1'b0, 2, 3, 20'h22223, 20'h22222, 8'd1, 4'h4);
        look(32'h1111_3000, 2'd0, 2'd0, 4'd0, 32'h1111_1000, 5'b10001, "R10 way1 present");
        do_refill(32'h00C0_3C00, 2'd0, 32'h8000_300C, 32'h3333_3024, 1'b0,
                  4'd0, 32'h3333_3C00, 5'b10001, "refill1");
        look(32'h00C0_3C00, 2'd0, 2'd2, 4'd0, 32'h3333_3C00, 5'b10001, "R7 refilled entry ring2");
        look(32'h1111_3000, 2'd0, 2'd0, 4'd2, 32'd0, 5'd0, "R7 first refill used way1");
        look(32'h2222_3000, 2'd0, 2'd0, 4'd0, 32'h2222_2000, 5'b10001, "R7 way2 kept");
        do_refill(32'h00D0_3000, 2'd1, 32'h8000_340C, 32'h4444_4004, 1'b1,
                  4'd6, 32'd0, 5'b10001, "refill2");
        look(32'h2222_3000, 2'd0, 2'd0, 4'd2, 32'd0, 5'd0, "R7 second refill used way2");
        look(32'h00D0_3000, 2'd0, 2'd0, 4'd0, 32'h4444_4000, 5'b10001, "R7 ring0 entry");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit();
        t_priv();
        t_deny();
        t_asid();
        t_multi();
        t_refill();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule